// File: doc/BRIEF.md
# Interrupt Return State Controller

This block keeps the interrupt-related control state of a small DSP-style CPU core. It sets the interrupt and mode registers to known values under reset and points the first fetch at address zero. It also saves and restores the two enable bits that matter around interrupt handling: the global interrupt enable for maskable interrupts and the separate enable for the nonmaskable interrupt (NMI).

The pipeline tells the block when an interrupt has been taken and supplies the return address. It also tells the block when a decoded branch goes through one of the two return pointers. A return branch redirects fetch to the saved pointer at once. The enable bit is restored only after the branch's delay slots, so instructions in those slots still run with the old enables. Software reaches every register through one write port and one read port, and both ports use the same select code.

Select codes: 0 mode register, 1 control/status register (CSR), 2 flag-set register, 3 flag-clear register, 4 interrupt enable register (IER), 5 interrupt flag register (IFR), 6 vector table pointer, 7 maskable return pointer (IRP), 8 NMI return pointer (NRP). Any other code reads zero and writes nothing. CSR layout: bit 0 is the global enable (GIE), bit 1 is the saved previous enable (PGIE), bit 8 is the endianness indicator, and all other bits read zero. The NMI enable is bit 1 of IER.

Top module: `irq_ret_ctl`

## Requirements
- R1: While reset is low at a clock edge, the mode register, IFR and the vector table pointer become zero and IER becomes 1 (only bit 0 set). Select codes 2 and 3 always read zero. IRP and NRP are not initialised.
- R2: Reset loads the CSR with 0x0100 when `strap_le` is 1 and with 0x0000 when it is 0. The endianness bit (bit 8) ignores writes.
- R3: While reset is held, and in the first cycle after it is released, `fetch_redir` is 1 with `fetch_addr` 0.
- R4: `int_take` loads IRP with `ret_addr`, copies GIE into PGIE and clears GIE, all at the same edge.
- R5: `nmi_take` loads NRP with `ret_addr` and clears the NMI enable at that edge.
- R6: An accepted `ret_irp` makes `fetch_redir` 1 for exactly one cycle, the cycle after the strobe, with `fetch_addr` equal to the IRP value at the strobe.
- R7: An accepted `ret_nrp` does the same with the NRP value. If both strobes are high together, the NMI return wins.
- R8: After a return accepted in cycle t, the enables keep their old values in cycles t+1 to t+5. In cycle t+6, GIE takes the PGIE value (maskable return) or the NMI enable reads 1 (NMI return).
- R9: Writing select 2 sets each IFR bit whose data bit is 1. Writing select 3 clears each IFR bit whose data bit is 1.
- R10: Writes with selects 0, 4, 6, 7 and 8 load the full register. A write with select 1 loads GIE from data bit 0 and PGIE from data bit 1. Every write is readable in the next cycle.
- R11: A return strobe that arrives while an earlier return is still waiting out its delay slots is ignored: there is no redirect and no enable change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_le | input | 1 | Endianness strap, 1 = little-endian, sampled in reset |
| int_take | input | 1 | Maskable interrupt taken this cycle |
| nmi_take | input | 1 | NMI taken this cycle |
| ret_addr | input | W | Return address captured on a take |
| ret_irp | input | 1 | Branch through IRP decoded |
| ret_nrp | input | 1 | Branch through NRP decoded |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Write select code |
| wr_data | input | W | Write data |
| rd_sel | input | 4 | Read select code |
| rd_data | output | W | Read data for `rd_sel`, combinational |
| gie | output | 1 | Global maskable interrupt enable |
| nmie | output | 1 | NMI enable |
| fetch_redir | output | 1 | Fetch redirect valid |
| fetch_addr | output | W | Fetch redirect target |

## Verification
Every register update from a take, a write or a flag set/clear is visible one edge after its strobe. The read port is combinational, so the bench samples it in the cycle after the write. A return redirect appears in the cycle after the strobe and lasts exactly one cycle. The enable restore lands six cycles after the strobe. The reference model in the bench records the edge at which each restore is due and compares the outputs at every falling edge, so a restore that comes one cycle early or late is caught.

// File: rtl/irq_ret_ctl.sv
module irq_ret_ctl #(
  parameter int W      = 32,
  parameter int NINT   = 16,
  parameter int DSLOTS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_le,
  input  logic         int_take,
  input  logic         nmi_take,
  input  logic [W-1:0] ret_addr,
  input  logic         ret_irp,
  input  logic         ret_nrp,
  input  logic         wr_en,
  input  logic [3:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [3:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         gie,
  output logic         nmie,
  output logic         fetch_redir,
  output logic [W-1:0] fetch_addr
);
  localparam int CW = $clog2(DSLOTS + 1);
  localparam logic [3:0] S_AMR = 4'd0, S_CSR = 4'd1, S_SET = 4'd2, S_CLR = 4'd3,
                         S_IER = 4'd4, S_IFR = 4'd5, S_TBL = 4'd6, S_IRP = 4'd7,
                         S_NRP = 4'd8;
  localparam int NMI_BIT = 1;

  logic [W-1:0]    amr_q, tbl_q, irp_q, nrp_q, redir_addr_q;
  logic [NINT-1:0] ifr_q, ier_q;
  logic            gie_q, pgie_q, le_q, boot_q, redir_q, kind_q;
  logic [CW-1:0]   cnt_q;

  wire ret_go = (ret_irp || ret_nrp) && (cnt_q == '0);
  wire apply  = (cnt_q == CW'(1));
  wire [W-1:0] csr_w = W'({7'b0, le_q, 6'b0, pgie_q, gie_q});

  function automatic logic wr_hit(input logic [3:0] s);
    return wr_en && (wr_sel == s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amr_q        <= '0;
      tbl_q        <= '0;
      ifr_q        <= '0;
      ier_q        <= NINT'(1);
      gie_q        <= 1'b0;
      pgie_q       <= 1'b0;
      le_q         <= strap_le;
      boot_q       <= 1'b1;
      redir_q      <= 1'b0;
      redir_addr_q <= '0;
      cnt_q        <= '0;
      kind_q       <= 1'b0;
    end else begin
      boot_q  <= 1'b0;
      redir_q <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      if (ret_go) begin
        redir_q      <= 1'b1;
        redir_addr_q <= ret_nrp ? nrp_q : irp_q;
        cnt_q        <= CW'(DSLOTS);
        kind_q       <= ret_nrp;
      end
      if (wr_hit(S_AMR)) amr_q <= wr_data;
      if (wr_hit(S_TBL)) tbl_q <= wr_data;
      if (wr_hit(S_IER)) ier_q <= wr_data[NINT-1:0];
      if (wr_hit(S_SET)) ifr_q <= ifr_q | wr_data[NINT-1:0];
      if (wr_hit(S_CLR)) ifr_q <= ifr_q & ~wr_data[NINT-1:0];
      if (wr_hit(S_CSR)) begin
        gie_q  <= wr_data[0];
        pgie_q <= wr_data[1];
      end
      if (apply && !kind_q) gie_q <= pgie_q;
      if (apply && kind_q)  ier_q[NMI_BIT] <= 1'b1;
      if (int_take) begin
        pgie_q <= gie_q;
        gie_q  <= 1'b0;
      end
      if (nmi_take) ier_q[NMI_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit(S_IRP)) irp_q <= wr_data;
    if (int_take)      irp_q <= ret_addr;
    if (wr_hit(S_NRP)) nrp_q <= wr_data;
    if (nmi_take)      nrp_q <= ret_addr;
  end

  always_comb begin
    case (rd_sel)
      S_AMR:   rd_data = amr_q;
      S_CSR:   rd_data = csr_w;
      S_IER:   rd_data = W'(ier_q);
      S_IFR:   rd_data = W'(ifr_q);
      S_TBL:   rd_data = tbl_q;
      S_IRP:   rd_data = irp_q;
      S_NRP:   rd_data = nrp_q;
      default: rd_data = '0;
    endcase
  end

  assign gie         = gie_q;
  assign nmie        = ier_q[NMI_BIT];
  assign fetch_redir = boot_q | redir_q;
  assign fetch_addr  = boot_q ? '0 : redir_addr_q;
endmodule

// File: rtl/irq_ret_ctl_chk.sv
module irq_ret_ctl_chk #(
  parameter int W    = 32,
  parameter int NINT = 16,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            int_take,
  input logic            nmi_take,
  input logic [W-1:0]    ret_addr,
  input logic            ret_irp,
  input logic            ret_nrp,
  input logic            fetch_redir,
  input logic [W-1:0]    fetch_addr,
  input logic            gie,
  input logic            nmie,
  input logic            pgie_q,
  input logic [W-1:0]    irp_q,
  input logic [W-1:0]    nrp_q,
  input logic [NINT-1:0] ier_q,
  input logic [NINT-1:0] ifr_q,
  input logic [CW-1:0]   cnt_q
);
  AST_RESET_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ier_q == NINT'(1) && ifr_q == '0)); // R1
  AST_BOOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fetch_redir && fetch_addr == '0)); // R3
  AST_INT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && rst_n) |=> (!gie && irp_q == $past(ret_addr) && pgie_q == $past(gie))); // R4
  AST_NMI_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> (!nmie && nrp_q == $past(ret_addr))); // R5
  AST_IRP_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_irp && !ret_nrp && cnt_q == '0) |=> (fetch_redir && fetch_addr == $past(irp_q))); // R6
  AST_NRP_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_nrp && cnt_q == '0) |=> (fetch_redir && fetch_addr == $past(nrp_q))); // R7
  AST_PENDING_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_irp || ret_nrp) && cnt_q != '0) |=> !fetch_redir); // R11
endmodule

bind irq_ret_ctl irq_ret_ctl_chk #(.W(W), .NINT(NINT), .CW(CW)) u_chk (.*);

// File: tb/tb_irq_ret_ctl.sv
`timescale 1ns/1ps
module tb_irq_ret_ctl;
  localparam int W = 32, NINT = 16, DSLOTS = 5;
  logic clk = 1'b0, rst_n = 1'b0, strap_le = 1'b1;
  logic int_take = 0, nmi_take = 0, ret_irp = 0, ret_nrp = 0, wr_en = 0;
  logic [W-1:0] ret_addr = '0, wr_data = '0;
  logic [3:0] wr_sel = '0, rd_sel = '0;
  logic [W-1:0] rd_data, fetch_addr;
  logic gie, nmie, fetch_redir;
  int tests = 0, fails = 0;

  irq_ret_ctl #(.W(W), .NINT(NINT), .DSLOTS(DSLOTS)) dut (.*);

  always #10 clk = ~clk;

  // behavioural reference state
  logic [W-1:0] m_amr, m_tbl, m_irp, m_nrp, m_raddr;
  logic [15:0] m_ifr, m_ier;
  logic m_gie, m_pgie, m_le, m_boot, m_redir, m_kind;
  bit irp_known = 0, nrp_known = 0, started = 0;
  int edge_no = 0, due = -1;

  always @(posedge clk) begin
    edge_no++;
    started = 1;
    if (!rst_n) begin
      m_amr = 0; m_tbl = 0; m_ifr = 0; m_ier = 16'h0001; m_gie = 0; m_pgie = 0;
      m_le = strap_le; m_boot = 1; m_redir = 0; due = -1;
    end else begin
      m_boot = 0; m_redir = 0;
      if (wr_en) case (wr_sel)
        0: m_amr = wr_data;
        1: begin m_gie = wr_data[0]; m_pgie = wr_data[1]; end
        2: m_ifr = m_ifr | wr_data[15:0];
        3: m_ifr = m_ifr & ~wr_data[15:0];
        4: m_ier = wr_data[15:0];
        6: m_tbl = wr_data;
        7: begin m_irp = wr_data; irp_known = 1; end
        8: begin m_nrp = wr_data; nrp_known = 1; end
        default: ;
      endcase
      if (edge_no == due) begin
        if (m_kind) m_ier[1] = 1; else m_gie = m_pgie;
      end
      if ((ret_irp || ret_nrp) && edge_no > due) begin
        m_redir = 1; m_kind = ret_nrp;
        m_raddr = ret_nrp ? m_nrp : m_irp;
        due = edge_no + DSLOTS;
      end
      if (int_take) begin m_pgie = m_gie; m_gie = 0; m_irp = ret_addr; irp_known = 1; end
      if (nmi_take) begin m_ier[1] = 0; m_nrp = ret_addr; nrp_known = 1; end
    end
  end

  function automatic logic [W-1:0] m_read(input logic [3:0] s);
    case (s)
      0: return m_amr;
      1: return W'({7'b0, m_le, 6'b0, m_pgie, m_gie});
      4: return W'(m_ier);
      5: return W'(m_ifr);
      6: return m_tbl;
      7: return m_irp;
      8: return m_nrp;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit pend = (edge_no <= due);
    string t;
    if (!started) return;
    t = m_boot ? "R3" : (m_kind ? "R7" : "R6");
    chk(t, W'(fetch_redir), W'(m_boot || m_redir));
    if (m_boot || m_redir) chk(t, fetch_addr, m_boot ? '0 : m_raddr);
    chk(pend ? "R8" : "R4", W'(gie), W'(m_gie));
    chk(pend ? "R8" : "R5", W'(nmie), W'(m_ier[1]));
    if (!((rd_sel == 7 && !irp_known) || (rd_sel == 8 && !nrp_known))) begin
      if (!rst_n) t = "R1";
      else if (rd_sel == 1) t = "R2";
      else if (rd_sel == 2 || rd_sel == 3 || rd_sel == 5) t = "R9";
      else t = "R10";
      chk(t, rd_data, m_read(rd_sel));
    end
  endtask

  int rs = 0;
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      int_take = 0; nmi_take = 0; ret_irp = 0; ret_nrp = 0; wr_en = 0;
      rs = (rs + 1) % 10;
      rd_sel = 4'(rs);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [W-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
  endtask

  task automatic do_reset(input logic le);
    strap_le = le; rst_n = 0;
    step(4);
    rst_n = 1;
    step();
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(1);                                  // R1 R2 R3
    for (int s = 0; s < 10; s++) begin
      rd_sel = 4'(s); #1; chk("R1", rd_data, m_read(4'(s)));
    end
    wr(4, 32'h0000_0013);                         // R10 NMI enable on
    wr(1, 32'h0000_0101);                         // R2 endian bit read-only
    wr(0, 32'hA5A5_5A5A);
    wr(6, 32'h0000_0400);
    wr(2, 32'h0000_00F0);                         // R9
    wr(3, 32'h0000_0030);
    step(10);
    int_take = 1; ret_addr = 32'h1234; step();    // R4
    step(3);
    ret_irp = 1; step();                          // R6
    ret_irp = 1; step();                          // R11
    chk("R11", W'(fetch_redir), 0);
    ret_nrp = 1; step();
    chk("R11", W'(fetch_redir), 0);
    step(8);                                      // R8 restore lands
    nmi_take = 1; ret_addr = 32'h8000; step();    // R5
    step(2);
    ret_nrp = 1; step();                          // R7
    step(8);
    wr(7, 32'h40);                                // R10
    wr(1, 32'h1);                                 // gie=1 pgie=0
    ret_irp = 1; ret_nrp = 1; step();             // R7 priority
    step(8);
    wr(8, 32'h90);
    nmi_take = 1; ret_addr = 32'h77; step();
    ret_irp = 1; step();
    step(8);
    do_reset(0);                                  // R2 big-endian
    step(10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule